// File: doc/BRIEF.md
# I2C Bus Phase Timing Engine

This block produces the SCL and SDA levels of an I2C master, one bus phase at a time. A byte engine asks for a phase (start, one data bit, repeated start or stop). The block then times every interval of that phase from programmed tick counts, and pulses a completion strobe when the phase ends. A common 8-bit divider sets one tick to (DIV+1) input clocks. Every counted interval lasts (count+1) ticks.

Each time the block releases SCL high, it waits a fixed overhead of 8 + 2*FILTER input clocks before the next interval starts. FILTER is the 3-bit input glitch-filter length. The overhead counts only clocks in which the sampled SCL line reads high, so a slave that holds SCL low stretches the phase. With no stretching, a data bit takes (DIV+1)*(LOW+HIGH+2) + 8 + 2*FILTER input clocks. LOW is the effective low count defined in R4. The counts come from three 32-bit timing words and a separate data-hold count.

Top module: `i2c_bus_timer`

## Requirements
- R1: While reset is asserted and right after it, sclOut and sdaOut are 1, phaseDone is 0 and reqReady is 1.
- R2: A data-bit phase lasts exactly (DIV+1)*(LEFF+1) + 8 + 2*FILTER + (DIV+1)*(HIGH+1) clocks from its acceptance edge to the edge that raises phaseDone. DIV is word3[23:16], HIGH is word2[7:0], and LEFF is defined in R4.
- R3: In a data-bit phase (reqKind 01), sdaOut takes reqBit (DIV+1)*(HOLD+1) clocks after acceptance, where HOLD is holdCount. sdaOut never changes while SCL is high during a bit.
- R4: The low interval of a bit or stop phase lasts LEFF+1 ticks. LEFF is the larger of SCL low (word2[15:8]) and HOLD+SETUP+1, with SETUP at word2[31:24]. SCL rises at the end of that interval.
- R5: A start phase (reqKind 00) pulls SDA low (DIV+1)*(SSU+1) clocks after acceptance, with SSU at word1[31:24]. It pulls SCL low and completes (DIV+1)*(SHD+1) clocks later, with SHD at word1[23:16].
- R6: A repeated start (reqKind 10) releases SDA at acceptance, and releases SCL after (DIV+1)*(REL+1) clocks, with REL at word3[7:0]. After the overhead it continues with the start timing of R5.
- R7: A stop (reqKind 11) drives SDA low at the hold point and raises SCL as in R4. After the overhead it raises SDA and completes after (DIV+1)*(PSU+1) clocks, with PSU at word1[15:8]. SCL is left high.
- R8: After SCL is released, 8 + 2*FILTER clocks with sclIn high must pass before the next interval. Clocks with sclIn low are not counted, so they add one clock each to the phase.
- R9: phaseDone is high for exactly one clock at the end of each phase. reqReady is high only when no phase runs. Request inputs presented during a phase have no effect on it.
- R10: Bits of the timing words outside the named fields have no effect on any timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Phase request, taken when reqReady is high |
| reqKind | input | 2 | Phase type: 00 start, 01 bit, 10 repeated start, 11 stop |
| reqBit | input | 1 | SDA value for a bit phase |
| timeWord1 | input | 32 | Start setup, start hold and stop setup counts |
| timeWord2 | input | 32 | Data setup, SCL low and SCL high counts |
| timeWord3 | input | 32 | Divider and repeated-start release count |
| holdCount | input | 8 | Data hold count in ticks |
| filterLen | input | 3 | Input filter length, adds to the overhead |
| sclIn | input | 1 | Sampled SCL line level |
| reqReady | output | 1 | Idle, a new request is accepted |
| phaseDone | output | 1 | One-clock pulse at the end of a phase |
| sclOut | output | 1 | SCL level to drive |
| sdaOut | output | 1 | SDA level to drive |

## Verification
Two things can meet on the same clock edge: the end of one phase and the acceptance of the next. In the same way, a request can arrive while a phase is still counting. The bench issues the next phase right after each completion pulse and checks its timing from its own acceptance edge. In some bit phases it keeps reqValid high, with a different kind and bit, for several cycles after acceptance. Those phases must complete on exactly the predicted cycle, with the originally requested SDA value, and reqReady must stay low throughout.

// File: rtl/i2c_phase_pkg.sv
`timescale 1ns/1ps
package i2c_phase_pkg;
  typedef enum logic [1:0] {
    PH_START  = 2'd0,
    PH_BIT    = 2'd1,
    PH_RSTART = 2'd2,
    PH_STOP   = 2'd3
  } phaseKind_e;

  typedef enum logic [2:0] {
    SEL_LOW, SEL_HIGH, SEL_SSU, SEL_SHD, SEL_PSU, SEL_REL
  } limitSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_REL, ST_RISE, ST_HIGH, ST_SSU, ST_SHD, ST_PSU
  } tmState_e;

  typedef struct packed {
    logic      clear;
    logic      riseMode;
    limitSel_e sel;
  } tmStrobe_t;
endpackage

// File: rtl/i2c_tm_datapath.sv
`timescale 1ns/1ps
module i2c_tm_datapath
  import i2c_phase_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 8,
  parameter int FILT_W = 3,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmStrobe_t         strobe,
  input  logic [WORD_W-1:0] timeWord1,
  input  logic [WORD_W-1:0] timeWord2,
  input  logic [WORD_W-1:0] timeWord3,
  input  logic [CNT_W-1:0]  holdCount,
  input  logic [FILT_W-1:0] filterLen,
  input  logic              sclIn,
  output logic              intervalEnd,
  output logic              holdHit,
  output logic              riseEnd
);
  localparam int CNT_X  = CNT_W + 1;
  localparam int W1_SSU = WORD_W - CNT_W;
  localparam int W1_SHD = W1_SSU - CNT_W;
  localparam int W1_PSU = W1_SHD - CNT_W;
  localparam int W2_DSU = WORD_W - CNT_W;
  localparam int W2_LOW = CNT_W;
  localparam int W3_DIV = 2 * CNT_W;
  localparam int BASE_OVH = 7;

  logic [CNT_W-1:0] startSu, startHd, stopSu, dataSu, sclLow, sclHigh, relCnt;
  logic [DIV_W-1:0] divVal, preCnt;
  logic [CNT_X-1:0] ivCnt, limit, lowLimit, setupEnd, riseLimit;
  logic             tick;
  logic             unusedCfg;

  assign startSu = timeWord1[W1_SSU +: CNT_W];
  assign startHd = timeWord1[W1_SHD +: CNT_W];
  assign stopSu  = timeWord1[W1_PSU +: CNT_W];
  assign dataSu  = timeWord2[W2_DSU +: CNT_W];
  assign sclLow  = timeWord2[W2_LOW +: CNT_W];
  assign sclHigh = timeWord2[0 +: CNT_W];
  assign divVal  = timeWord3[W3_DIV +: DIV_W];
  assign relCnt  = timeWord3[0 +: CNT_W];
  assign unusedCfg = ^{timeWord1[W1_PSU-1:0], timeWord2[W2_DSU-1:W2_LOW+CNT_W],
                       timeWord3[WORD_W-1:W3_DIV+DIV_W], timeWord3[W3_DIV-1:CNT_W]};

  // low interval is stretched so hold plus setup always fit inside it
  assign setupEnd  = CNT_X'(holdCount) + CNT_X'(dataSu) + CNT_X'(1);
  assign lowLimit  = (CNT_X'(sclLow) >= setupEnd) ? CNT_X'(sclLow) : setupEnd;
  assign riseLimit = CNT_X'({filterLen, 1'b0}) + CNT_X'(BASE_OVH);

  always_comb begin
    case (strobe.sel)
      SEL_HIGH: limit = CNT_X'(sclHigh);
      SEL_SSU:  limit = CNT_X'(startSu);
      SEL_SHD:  limit = CNT_X'(startHd);
      SEL_PSU:  limit = CNT_X'(stopSu);
      SEL_REL:  limit = CNT_X'(relCnt);
      default:  limit = lowLimit;
    endcase
  end

  assign tick        = !strobe.riseMode && (preCnt == divVal);
  assign intervalEnd = tick && (ivCnt == limit);
  assign holdHit     = tick && (ivCnt == CNT_X'(holdCount));
  assign riseEnd     = strobe.riseMode && sclIn && (ivCnt == riseLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      ivCnt  <= '0;
    end else if (strobe.clear) begin
      preCnt <= '0;
      ivCnt  <= '0;
    end else if (strobe.riseMode) begin
      if (sclIn) ivCnt <= ivCnt + 1'b1;
    end else if (tick) begin
      preCnt <= '0;
      ivCnt  <= ivCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.riseMode) |-> (ivCnt <= limit));
  p_rise_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.riseMode |-> (ivCnt <= riseLimit));
  p_stretch_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.riseMode && !sclIn && !strobe.clear) |=> (ivCnt == $past(ivCnt)));
endmodule

// File: rtl/i2c_tm_control.sv
`timescale 1ns/1ps
module i2c_tm_control
  import i2c_phase_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       reqBit,
  input  logic       intervalEnd,
  input  logic       holdHit,
  input  logic       riseEnd,
  output tmStrobe_t  strobe,
  output logic       reqReady,
  output logic       phaseDone,
  output logic       sclOut,
  output logic       sdaOut
);
  tmState_e   state;
  phaseKind_e kind;
  logic       bitVal;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe.riseMode = (state == ST_RISE);
    strobe.clear    = (state == ST_IDLE) || intervalEnd || riseEnd;
    case (state)
      ST_HIGH: strobe.sel = SEL_HIGH;
      ST_SSU:  strobe.sel = SEL_SSU;
      ST_SHD:  strobe.sel = SEL_SHD;
      ST_PSU:  strobe.sel = SEL_PSU;
      ST_REL:  strobe.sel = SEL_REL;
      default: strobe.sel = SEL_LOW;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= PH_START;
      bitVal    <= 1'b1;
      sclOut    <= 1'b1;
      sdaOut    <= 1'b1;
      phaseDone <= 1'b0;
    end else begin
      phaseDone <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          kind   <= phaseKind_e'(reqKind);
          bitVal <= reqBit;
          case (phaseKind_e'(reqKind))
            PH_START:  state <= ST_SSU;
            PH_RSTART: begin state <= ST_REL; sdaOut <= 1'b1; end
            default:   state <= ST_LOW;
          endcase
        end
        ST_LOW: begin
          if (holdHit) sdaOut <= (kind == PH_BIT) ? bitVal : 1'b0;
          if (intervalEnd) begin sclOut <= 1'b1; state <= ST_RISE; end
        end
        ST_REL: if (intervalEnd) begin sclOut <= 1'b1; state <= ST_RISE; end
        ST_RISE: if (riseEnd) begin
          case (kind)
            PH_BIT:  state <= ST_HIGH;
            PH_STOP: state <= ST_PSU;
            default: state <= ST_SSU;
          endcase
        end
        ST_HIGH: if (intervalEnd) begin
          sclOut <= 1'b0; phaseDone <= 1'b1; state <= ST_IDLE;
        end
        ST_SSU: if (intervalEnd) begin sdaOut <= 1'b0; state <= ST_SHD; end
        ST_SHD: if (intervalEnd) begin
          sclOut <= 1'b0; phaseDone <= 1'b1; state <= ST_IDLE;
        end
        ST_PSU: if (intervalEnd) begin
          sdaOut <= 1'b1; phaseDone <= 1'b1; state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_sda_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && $past(sclOut) && (sdaOut != $past(sdaOut)))
      |-> ($past(state) == ST_SSU || $past(state) == ST_PSU));
  p_scl_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOut) |-> ($past(state) == ST_LOW || $past(state) == ST_REL));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    phaseDone |=> !phaseDone);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    phaseDone |-> reqReady);
endmodule

// File: rtl/i2c_bus_timer.sv
`timescale 1ns/1ps
module i2c_bus_timer
  import i2c_phase_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 8,
  parameter int FILT_W = 3,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqBit,
  input  logic [WORD_W-1:0] timeWord1,
  input  logic [WORD_W-1:0] timeWord2,
  input  logic [WORD_W-1:0] timeWord3,
  input  logic [CNT_W-1:0]  holdCount,
  input  logic [FILT_W-1:0] filterLen,
  input  logic              sclIn,
  output logic              reqReady,
  output logic              phaseDone,
  output logic              sclOut,
  output logic              sdaOut
);
  tmStrobe_t strobe;
  logic      intervalEnd, holdHit, riseEnd;

  i2c_tm_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqBit(reqBit),
    .intervalEnd(intervalEnd), .holdHit(holdHit), .riseEnd(riseEnd), .strobe(strobe),
    .reqReady(reqReady), .phaseDone(phaseDone), .sclOut(sclOut), .sdaOut(sdaOut)
  );

  i2c_tm_datapath #(.CNT_W(CNT_W), .DIV_W(DIV_W), .FILT_W(FILT_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timeWord1(timeWord1), .timeWord2(timeWord2),
    .timeWord3(timeWord3), .holdCount(holdCount), .filterLen(filterLen), .sclIn(sclIn),
    .intervalEnd(intervalEnd), .holdHit(holdHit), .riseEnd(riseEnd)
  );
endmodule

// File: tb/i2c_bus_timer_tb.sv
`timescale 1ns/1ps
module i2c_bus_timer_tb;
  import i2c_phase_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, reqValid, reqBit, sclIn, reqReady, phaseDone, sclOut, sdaOut;
  logic [1:0]  reqKind;
  logic [31:0] tw1, tw2, tw3;
  logic [7:0]  holdCount;
  logic [2:0]  filterLen;

  int cDiv, cL, cH, cSsu, cShd, cPsu, cDsu, cHold, cRel, cFilt;
  int stretchReq = 0, stretchCnt = 0;
  int errors = 0, checks = 0, cycles = 0;
  int seedVal;

  i2c_bus_timer u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqBit(reqBit),
    .timeWord1(tw1), .timeWord2(tw2), .timeWord3(tw3), .holdCount(holdCount),
    .filterLen(filterLen), .sclIn(sclIn), .reqReady(reqReady), .phaseDone(phaseDone),
    .sclOut(sclOut), .sdaOut(sdaOut)
  );

  // slave model: holds SCL low for stretchReq clocks after each release
  always @(posedge clk) begin
    if (!sclOut) stretchCnt <= 0;
    else if (stretchCnt < stretchReq) stretchCnt <= stretchCnt + 1;
  end
  assign sclIn = sclOut && (stretchCnt >= stretchReq);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R9 watchdog: actual=%0d expected<%0d", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int tk(int c);
    return (c + 1) * (cDiv + 1);
  endfunction
  function automatic int ovh();
    return 8 + 2 * cFilt;
  endfunction
  function automatic int lowEff();
    return (cL >= cHold + cDsu + 1) ? cL : cHold + cDsu + 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setCfg(input int d, input int l, input int h, input int ssu, input int shd,
                        input int psu, input int dsu, input int hld, input int rel, input int f);
    cDiv = d; cL = l; cH = h; cSsu = ssu; cShd = shd; cPsu = psu;
    cDsu = dsu; cHold = hld; cRel = rel; cFilt = f;
    tw1 = {8'(ssu), 8'(shd), 8'(psu), 8'($urandom)};
    tw2 = {8'(dsu), 8'($urandom), 8'(l), 8'(h)};
    tw3 = {8'($urandom), 8'(d), 8'($urandom), 8'(rel)};
    holdCount = 8'(hld);
    filterLen = 3'(f);
  endtask

  // called at a negedge while idle; event index k after acceptance is seen as n = k+1
  task automatic runPhase(input logic [1:0] kind, input logic b, input int stretch,
                          input bit holdReq, input string tag);
    int n = 0, doneN = -1, riseN = -1, firstN = -1, lastN = -1;
    int kRise = -1, kDone = 0, kSda = 0, expFirst = -1, expLast = -1;
    int kHold = tk(cHold);
    bit readyBad = 0;
    logic prevS = sdaOut, prevC = sclOut, startSda = sdaOut;
    logic expScl = 1'b0, expSda = 1'b0;
    case (kind)
      PH_BIT: begin
        kRise = tk(lowEff()); kDone = kRise + ovh() + stretch + tk(cH);
        expSda = b;
        if (b != startSda) begin expFirst = kHold + 1; expLast = kHold + 1; end
      end
      PH_STOP: begin
        kRise = tk(lowEff()); kDone = kRise + ovh() + stretch + tk(cPsu);
        expScl = 1'b1; expSda = 1'b1;
        expFirst = startSda ? kHold + 1 : kDone + 1; expLast = kDone + 1;
      end
      PH_START: begin
        kDone = tk(cSsu) + tk(cShd);
        expFirst = tk(cSsu) + 1; expLast = expFirst;
      end
      default: begin
        kRise = tk(cRel); kSda = kRise + ovh() + stretch + tk(cSsu);
        kDone = kSda + tk(cShd);
        expFirst = startSda ? kSda + 1 : 1; expLast = kSda + 1;
      end
    endcase
    stretchReq = stretch;
    reqKind = kind; reqBit = b; reqValid = 1'b1;
    while (doneN < 0 && n < 40000) begin
      @(posedge clk); n++; @(negedge clk);
      if (n == 1) begin
        if (holdReq) begin reqKind = ~kind; reqBit = ~b; end
        else reqValid = 1'b0;
      end
      if (n == 5) reqValid = 1'b0;
      if (sclOut && !prevC) riseN = n;
      prevC = sclOut;
      if (sdaOut !== prevS) begin
        if (firstN < 0) firstN = n;
        lastN = n; prevS = sdaOut;
      end
      if (phaseDone) doneN = n;
      else if (reqReady) readyBad = 1;
    end
    check({tag, " phase end cycle"}, doneN, kDone + 1);
    check({tag, " SCL release cycle"}, riseN, (kRise < 0) ? -1 : kRise + 1);
    check({tag, " first SDA edge"}, firstN, expFirst);
    check({tag, " last SDA edge"}, lastN, expLast);
    check({tag, " final SCL"}, int'(sclOut), int'(expScl));
    check({tag, " final SDA"}, int'(sdaOut), int'(expSda));
    check("R9 ready low while busy", int'(readyBad), 0);
    @(posedge clk); @(negedge clk);
    check("R9 single done pulse", int'(phaseDone), 0);
    stretchReq = 0;
  endtask

  task automatic runSeq(input int nBits, input int stretch, input string bitTag);
    runPhase(PH_START, 1'b0, 0, 0, "R5 start");
    for (int i = 0; i < nBits; i++) begin
      if (i == 1) runPhase(PH_BIT, 1'($urandom), stretch, 0, "R8 stretched bit");
      else if (i == 2) runPhase(PH_BIT, 1'($urandom), 0, 1, "R9 bit with busy request");
      else runPhase(PH_BIT, 1'($urandom), 0, 0, bitTag);
    end
    runPhase(PH_BIT, 1'b0, 0, 0, bitTag);
    runPhase(PH_RSTART, 1'b0, stretch, 0, "R6 repeated start");
    runPhase(PH_BIT, 1'b1, 0, 0, "R2 bit");
    runPhase(PH_STOP, 1'b0, 0, 0, "R7 stop");
  endtask

  initial begin
    seedVal = $urandom(20240611);
    rstN = 1'b0; reqValid = 1'b0; reqKind = 2'd0; reqBit = 1'b0;
    setCfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset SCL", int'(sclOut), 1);
    check("R1 reset SDA", int'(sdaOut), 1);
    check("R1 reset done", int'(phaseDone), 0);
    check("R1 reset ready", int'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset SCL", int'(sclOut), 1);

    // minimum counts
    runSeq(2, 0, "R3 bit min");
    // low interval shorter than hold plus setup
    setCfg(1, 2, 1, 1, 2, 1, 2, 3, 1, 1);
    runSeq(3, 2, "R4 extended low");
    // largest divider, garbage in unused word bits
    setCfg(255, 2, 1, 1, 1, 1, 0, 0, 1, 2);
    runSeq(1, 0, "R10 bit");
    // longest filter with stretching
    setCfg(0, 6, 3, 2, 2, 2, 1, 1, 2, 7);
    runSeq(3, 5, "R3 bit");

    for (int c = 0; c < 6; c++) begin
      setCfg($urandom_range(3, 0), $urandom_range(20, 4), $urandom_range(12, 0),
             $urandom_range(9, 0), $urandom_range(9, 0), $urandom_range(9, 0),
             $urandom_range(4, 0), $urandom_range(3, 0), $urandom_range(9, 0),
             $urandom_range(7, 0));
      runSeq(4, $urandom_range(4, 0), "R3 random bit");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule